// File: doc/BRIEF.md
# Polled Serial Port with Byte Register File

This block is a serial transmitter and receiver that software drives entirely by polling. A processor-side bus performs single-cycle byte reads and writes at offsets 0 through 8. Software loads a 13-bit bit-rate divisor, selects the character format and enables each direction through control registers. It then exchanges characters through one data offset. A write to that offset fills the transmit holding register, and a read from it returns the receive holding register.

A shared baud generator pulses once every `divisor` clocks. Each serial bit lasts 16 of those pulses. A divisor of zero stops the generator.

The transmitter finite state machine (FSM) has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. It moves as follows:
- TX_IDLE to TX_START on a baud pulse when a byte is pending and the transmitter is enabled. This is the step that empties the holding register.
- TX_START to TX_DATA after one bit time.
- TX_DATA to TX_PARITY or to TX_STOP after the last data bit.
- TX_PARITY to TX_STOP after one bit time.
- TX_STOP to TX_IDLE after one bit time.
- Any state to TX_IDLE when the transmitter is disabled.

The receiver FSM has the states RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP. It moves as follows:
- RX_IDLE to RX_START on a high-to-low change of the synchronised line.
- RX_START to RX_DATA when the line is still low at the half-bit sample.
- RX_START to RX_IDLE when the line is high at the half-bit sample, which rejects a glitch.
- RX_DATA to RX_PARITY or to RX_STOP after the last data bit.
- RX_PARITY to RX_STOP after one bit time.
- RX_STOP to RX_IDLE, delivering the byte only when the stop sample is high.
- Any state to RX_IDLE when the receiver is disabled.

Top module: `uart_poll_periph`

## Requirements
- R1: After reset every offset 0..8 reads 0x00, except the status offset 4, which reads 0x80 (transmit-empty bit 7 set, receive-full bit 5 clear).
- R2: The following offsets read back the last value written: 0 (divisor high, only bits 4:0 kept, upper bits read 0), 1 (divisor low), 2, 3, 5, 6 and 8. Writes to offset 4 have no effect.
- R3: A write to offset 7 clears status bit 7. The bit returns to 1 once the byte has moved into the transmit shifter.
- R4: With offset 2 = 0x00, the TX pin sends one low start bit, 8 data bits LSB first and one high stop bit. Each bit lasts 16 × divisor clocks, where divisor = {offset0[4:0], offset1}.
- R5: With offset 2 bit 1 set, an even-parity bit is sent between the data bits and the stop bit.
- R6: With offset 2 bit 4 set, 9 data bits are sent, and the ninth bit is always 0.
- R7: With offset 3 bit 3 clear, TX stays high and a written byte is held (status bit 7 stays 0) until the bit is set.
- R8: A received frame with a high stop bit sets status bit 5, and a read of offset 7 then returns the byte (data LSB first, 16 samples per bit).
- R9: A read of offset 7 while status bit 5 is set clears status bit 5.
- R10: A frame whose stop bit samples low is discarded and leaves status bit 5 clear. The receiver then accepts the next good frame.
- R11: With offset 3 bit 2 clear, incoming frames leave status bit 5 clear.
- R12: A low pulse shorter than half a bit on RX is rejected as a start bit and delivers nothing.
- R13: With a divisor of 0 no baud pulse occurs. A written byte stays pending and TX stays high until a nonzero divisor is written, and then it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
The bench builds the block with its default parameters: a 13-bit divisor and 16 samples per bit. At run time it programs divisors of 2 and 3, so a whole frame takes a few hundred clocks. This allows back-to-back transmit frames, parity and 9-bit formats, and receive frames with good and bad stop bits, all within a short run. The zero-divisor case shows the stopped generator, and the change from 0 to 3 shows that a held byte leaves once the generator restarts.

// File: rtl/uart_poll_pkg.sv
package uart_poll_pkg;

    // Register offsets
    localparam logic [3:0] OFF_DIVH  = 4'd0;
    localparam logic [3:0] OFF_DIVL  = 4'd1;
    localparam logic [3:0] OFF_CTLA  = 4'd2;
    localparam logic [3:0] OFF_CTLB  = 4'd3;
    localparam logic [3:0] OFF_STAT  = 4'd4;
    localparam logic [3:0] OFF_STAT2 = 4'd5;
    localparam logic [3:0] OFF_CTLC  = 4'd6;
    localparam logic [3:0] OFF_DATA  = 4'd7;
    localparam logic [3:0] OFF_CTLD  = 4'd8;

    // Bit positions that the logic decodes
    localparam int CTLA_NINE_BIT = 4;
    localparam int CTLA_PAR_BIT  = 1;
    localparam int CTLB_TXEN_BIT = 3;
    localparam int CTLB_RXEN_BIT = 2;
    localparam int STAT_TXE_BIT  = 7;
    localparam int STAT_RXF_BIT  = 5;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (divisor == '0) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= divisor - 1'b1) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R13
    baud_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> !tick);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_poll_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       nine_bits,
    input  logic       par_en,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       load_ack,
    output logic       tx_o
);

    localparam int CW = $clog2(OVS);
    localparam int SW = 9;
    localparam int BW = $clog2(SW + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

    tx_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [BW-1:0]  bit_q, bit_d;
    logic [SW-1:0]  sh_q, sh_d;
    logic           par_q, par_d;
    logic           last_tick;
    logic [BW-1:0]  last_bit;

    assign last_tick = tick && (cnt_q == CNT_LAST);
    assign last_bit  = nine_bits ? BW'(SW - 1) : BW'(SW - 2);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        bit_d    = bit_q;
        sh_d     = sh_q;
        par_d    = par_q;
        load_ack = 1'b0;
        if (!tx_en) begin
            state_d = TX_IDLE;
            cnt_d   = '0;
        end else begin
            if (tick && state_q != TX_IDLE) begin
                cnt_d = last_tick ? '0 : cnt_q + 1'b1;
            end
            unique case (state_q)
                TX_IDLE: begin
                    if (tick && hold_full) begin
                        state_d  = TX_START;
                        cnt_d    = '0;
                        bit_d    = '0;
                        sh_d     = {1'b0, hold_data};
                        par_d    = ^hold_data;
                        load_ack = 1'b1;
                    end
                end
                TX_START: begin
                    if (last_tick) state_d = TX_DATA;
                end
                TX_DATA: begin
                    if (last_tick) begin
                        sh_d = sh_q >> 1;
                        if (bit_q == last_bit) begin
                            state_d = par_en ? TX_PARITY : TX_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                TX_PARITY: begin
                    if (last_tick) state_d = TX_STOP;
                end
                TX_STOP: begin
                    if (last_tick) state_d = TX_IDLE;
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            par_q   <= par_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START:  tx_o = 1'b0;
            TX_DATA:   tx_o = sh_q[0];
            TX_PARITY: tx_o = par_q;
            default:   tx_o = 1'b1;
        endcase
    end

    // R7
    tx_te_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state_q == TX_IDLE && tx_o));

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_poll_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_en,
    input  logic       nine_bits,
    input  logic       par_en,
    input  logic       rx_i,
    output logic       rx_done,
    output logic [7:0] rx_byte
);

    localparam int CW = $clog2(OVS);
    localparam int SW = 9;
    localparam int BW = $clog2(SW + 1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);

    rx_state_e      state_q, state_d;
    logic [1:0]     sync_q;
    logic           prev_q;
    logic           line;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [BW-1:0]  bit_q, bit_d;
    logic [SW-1:0]  sh_q, sh_d;
    logic           done_d;
    logic [BW-1:0]  last_bit;

    assign line     = sync_q[1];
    assign last_bit = nine_bits ? BW'(SW - 1) : BW'(SW - 2);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        done_d  = 1'b0;
        if (!rx_en) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (prev_q && !line) begin
                        state_d = RX_START;
                        cnt_d   = '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_d   = '0;
                        bit_d   = '0;
                        state_d = line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        sh_d  = {line, sh_q[SW-1:1]};
                        if (bit_q == last_bit) begin
                            state_d = par_en ? RX_PARITY : RX_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d   = '0;
                        state_d = RX_STOP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d   = '0;
                        state_d = RX_IDLE;
                        done_d  = line;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sync_q  <= 2'b11;
            prev_q  <= 1'b1;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            sync_q  <= {sync_q[0], rx_i};
            if (tick) prev_q <= line;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_done <= 1'b0;
            rx_byte <= '0;
        end else begin
            rx_done <= done_d;
            if (done_d) rx_byte <= nine_bits ? sh_q[7:0] : sh_q[8:1];
        end
    end

    // R10
    rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(line));

endmodule

// File: rtl/uart_poll_periph.sv
module uart_poll_periph
    import uart_poll_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_i,
    output logic       tx_o
);

    localparam int HI_W = DIV_W - 8;

    logic [HI_W-1:0] divh_q;
    logic [7:0]      divl_q, ctla_q, ctlb_q, stat2_q, ctlc_q, ctld_q;
    logic [7:0]      hold_q, rdr_q;
    logic            hold_full_q, rdrf_q;
    logic            wr_en, rd_en;
    logic            tick, tx_load_ack, rx_done;
    logic [7:0]      rx_byte;
    logic [7:0]      stat_byte;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_comb begin
        stat_byte = '0;
        stat_byte[STAT_TXE_BIT] = !hold_full_q;
        stat_byte[STAT_RXF_BIT] = rdrf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divh_q  <= '0;
            divl_q  <= '0;
            ctla_q  <= '0;
            ctlb_q  <= '0;
            stat2_q <= '0;
            ctlc_q  <= '0;
            ctld_q  <= '0;
            hold_q  <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFF_DIVH:  divh_q  <= bus_wdata[HI_W-1:0];
                OFF_DIVL:  divl_q  <= bus_wdata;
                OFF_CTLA:  ctla_q  <= bus_wdata;
                OFF_CTLB:  ctlb_q  <= bus_wdata;
                OFF_STAT2: stat2_q <= bus_wdata;
                OFF_CTLC:  ctlc_q  <= bus_wdata;
                OFF_DATA:  hold_q  <= bus_wdata;
                OFF_CTLD:  ctld_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            rdrf_q      <= 1'b0;
            rdr_q       <= '0;
        end else begin
            if (wr_en && bus_addr == OFF_DATA) hold_full_q <= 1'b1;
            else if (tx_load_ack)              hold_full_q <= 1'b0;
            if (rx_done) begin
                rdrf_q <= 1'b1;
                rdr_q  <= rx_byte;
            end else if (rd_en && bus_addr == OFF_DATA) begin
                rdrf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                OFF_DIVH:  bus_rdata = 8'(divh_q);
                OFF_DIVL:  bus_rdata = divl_q;
                OFF_CTLA:  bus_rdata = ctla_q;
                OFF_CTLB:  bus_rdata = ctlb_q;
                OFF_STAT:  bus_rdata = stat_byte;
                OFF_STAT2: bus_rdata = stat2_q;
                OFF_CTLC:  bus_rdata = ctlc_q;
                OFF_DATA:  bus_rdata = rdr_q;
                OFF_CTLD:  bus_rdata = ctld_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    uart_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor ({divh_q, divl_q}),
        .tick    (tick)
    );

    uart_tx_engine #(.OVS(OVS)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_en     (ctlb_q[CTLB_TXEN_BIT]),
        .nine_bits (ctla_q[CTLA_NINE_BIT]),
        .par_en    (ctla_q[CTLA_PAR_BIT]),
        .hold_full (hold_full_q),
        .hold_data (hold_q),
        .load_ack  (tx_load_ack),
        .tx_o      (tx_o)
    );

    uart_rx_engine #(.OVS(OVS)) rx_i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_en     (ctlb_q[CTLB_RXEN_BIT]),
        .nine_bits (ctla_q[CTLA_NINE_BIT]),
        .par_en    (ctla_q[CTLA_PAR_BIT]),
        .rx_i      (rx_i),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte)
    );

    // R3
    txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full_q) |-> $past(tx_load_ack));

    // R8
    rdrf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (rdrf_q && rdr_q == $past(rx_byte)));

    // R9
    rdrf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == OFF_DATA && rdrf_q && !rx_done) |=> !rdrf_q);

endmodule

// File: tb/uart_poll_periph_tb_top.sv
module uart_poll_periph_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_i = 1'b1;
    logic       tx_o;

    int n_chk = 0;
    int n_bad = 0;
    int bit_clks = 32;
    bit m_nine = 1'b0;
    bit m_par = 1'b0;
    bit mon_busy = 1'b0;
    logic mon_prev = 1'b1;

    typedef struct {
        logic [11:0] bits;
        int          nb;
        int          bclk;
        string       req;
    } frame_t;

    frame_t txq[$];

    always #5 clk = ~clk;

    uart_poll_periph dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_i      (rx_i),
        .tx_o      (tx_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string req);
        logic [7:0] d;
        bus_read(a, d);
        check(req, int'(d), int'(e));
    endtask

    // Driver side of the scoreboard: the expected TX frame.
    task automatic push_tx(input logic [7:0] d, input string req);
        frame_t f;
        int     k;
        f.bits = '1;
        f.bits[0] = 1'b0;
        k = 1;
        for (int i = 0; i < 8; i++) begin
            f.bits[k] = d[i];
            k++;
        end
        if (m_nine) begin
            f.bits[k] = 1'b0;
            k++;
        end
        if (m_par) begin
            f.bits[k] = ^d;
            k++;
        end
        f.bits[k] = 1'b1;
        f.nb   = k + 1;
        f.bclk = bit_clks;
        f.req  = req;
        txq.push_back(f);
    endtask

    task automatic poll_txe(input string req);
        logic [7:0] d;
        int         t;
        t = 0;
        d = '0;
        while (d[7] == 1'b0 && t < 2000) begin
            bus_read(4'd4, d);
            t++;
        end
        check(req, int'(d[7]), 1);
    endtask

    task automatic wait_tx_done(input string req);
        int t;
        t = 0;
        while ((txq.size() != 0 || mon_busy) && t < 30000) begin
            @(negedge clk);
            t++;
        end
        check(req, txq.size(), 0);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stop);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            repeat (bit_clks) @(negedge clk);
        end
        rx_i = stop;
        repeat (bit_clks) @(negedge clk);
        rx_i = 1'b1;
        repeat (bit_clks) @(negedge clk);
    endtask

    // Monitor side of the scoreboard: decode TX and compare.
    initial begin
        frame_t      f;
        logic [11:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && mon_prev && !tx_o) begin
                if (txq.size() == 0) begin
                    check("R7 unexpected start bit", 1, 0);
                end else begin
                    mon_busy = 1'b1;
                    f = txq.pop_front();
                    got = '1;
                    repeat (f.bclk / 2) @(negedge clk);
                    got[0] = tx_o;
                    for (int i = 1; i < f.nb; i++) begin
                        repeat (f.bclk) @(negedge clk);
                        got[i] = tx_o;
                    end
                    check(f.req, int'(got), int'(f.bits));
                    mon_busy = 1'b0;
                end
            end
            mon_prev = tx_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a <= 8; a++) begin
            expect_reg(4'(a), (a == 4) ? 8'h80 : 8'h00, "R1");
        end

        // R2 readback and ignored status write
        for (int a = 0; a <= 8; a++) begin
            if (a != 4 && a != 7) bus_write(4'(a), 8'hFF);
        end
        for (int a = 0; a <= 8; a++) begin
            if (a != 4 && a != 7) expect_reg(4'(a), (a == 0) ? 8'h1F : 8'hFF, "R2");
        end
        bus_write(4'd4, 8'h00);
        expect_reg(4'd4, 8'h80, "R2 status write ignored");
        for (int a = 0; a <= 8; a++) begin
            if (a != 4 && a != 7) bus_write(4'(a), 8'h00);
        end

        // Divisor 2, receiver only
        bus_write(4'd1, 8'd2);
        bit_clks = 32;
        bus_write(4'd3, 8'h04);

        // R3 / R7: byte held while transmitter disabled
        bus_write(4'd7, 8'hA5);
        expect_reg(4'd4, 8'h00, "R3 write clears empty bit");
        repeat (200) @(negedge clk);
        check("R7 tx idle high", int'(tx_o), 1);
        expect_reg(4'd4, 8'h00, "R7 byte held");

        // R4 8N1 frames, back to back
        push_tx(8'hA5, "R4");
        bus_write(4'd3, 8'h0C);
        poll_txe("R3 empty bit returns");
        push_tx(8'h3C, "R4");
        bus_write(4'd7, 8'h3C);
        wait_tx_done("R4");

        // R5 even parity
        bus_write(4'd2, 8'h02);
        m_par = 1'b1;
        push_tx(8'h01, "R5");
        bus_write(4'd7, 8'h01);
        poll_txe("R5");
        push_tx(8'h03, "R5");
        bus_write(4'd7, 8'h03);
        wait_tx_done("R5");

        // R6 nine data bits
        bus_write(4'd2, 8'h10);
        m_par = 1'b0;
        m_nine = 1'b1;
        push_tx(8'hFF, "R6");
        bus_write(4'd7, 8'hFF);
        wait_tx_done("R6");
        bus_write(4'd2, 8'h00);
        m_nine = 1'b0;

        // R13 divisor zero
        bus_write(4'd1, 8'd0);
        bus_write(4'd7, 8'h77);
        repeat (300) @(negedge clk);
        check("R13 tx high", int'(tx_o), 1);
        expect_reg(4'd4, 8'h00, "R13 byte pending");
        bit_clks = 48;
        push_tx(8'h77, "R13");
        bus_write(4'd1, 8'd3);
        wait_tx_done("R13");
        bus_write(4'd1, 8'd2);
        bit_clks = 32;
        repeat (50) @(negedge clk);

        // R8 / R9 receive
        send_rx(8'h5A, 1'b1);
        expect_reg(4'd4, 8'hA0, "R8 full bit set");
        expect_reg(4'd7, 8'h5A, "R8 data");
        expect_reg(4'd4, 8'h80, "R9 full bit cleared");
        send_rx(8'h81, 1'b1);
        expect_reg(4'd7, 8'h81, "R8 data");

        // R10 bad stop bit
        send_rx(8'h33, 1'b0);
        repeat (2 * bit_clks) @(negedge clk);
        expect_reg(4'd4, 8'h80, "R10 frame dropped");
        send_rx(8'h96, 1'b1);
        expect_reg(4'd4, 8'hA0, "R10 recovery");
        expect_reg(4'd7, 8'h96, "R10 recovery data");

        // R11 receiver disabled
        bus_write(4'd3, 8'h08);
        send_rx(8'h44, 1'b1);
        expect_reg(4'd4, 8'h80, "R11 ignored");
        bus_write(4'd3, 8'h0C);
        repeat (20) @(negedge clk);

        // R12 short glitch
        @(negedge clk);
        rx_i = 1'b0;
        repeat (6) @(negedge clk);
        rx_i = 1'b1;
        repeat (12 * bit_clks) @(negedge clk);
        expect_reg(4'd4, 8'h80, "R12 glitch rejected");
        send_rx(8'hE1, 1'b1);
        expect_reg(4'd7, 8'hE1, "R12 next frame");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule